// File: doc/BRIEF.md
# Peripheral Interrupt Aggregator

This block gathers the interrupt request levels of ten peripheral sources (four GPIO banks, three LED blinkers, an SPI engine, an SMBus controller and a one-wire controller) and merges them into a single host interrupt line. It also holds a small interrupt time base, which is a power-of-two prescaler followed by a tick counter. When the counter reaches a programmed count, it raises an eleventh request. Software reaches four word registers through a simple synchronous bus. Each register is selected by byte offset, writes take effect on the clock edge where the write strobe is high, and read data is registered and valid one cycle after the address.

The host line has two styles. In level style it stays high for as long as any unmasked request is present. In edge style it produces a single-cycle pulse each time the combined unmasked request goes from quiet to active. The status register shows the raw request levels and is not affected by the mask bits. Peripheral requests are cleared at the peripheral itself. The timer request is cleared by rewriting the timer count register.

Top module: `periph_irq_agg`

## Requirements
- R1: After synchronous reset, `irq_out` is 0 and all four registers read as 0.
- R2: The control register sits at offset 0x00. Bit 0 is the global enable (1 = enabled). Bit 1 selects the output style (1 = rising-edge pulse, 0 = high level). Bits 2..7 are group mask bits (1 = group blocked). Reads return bits 7..0, and the upper bits read as 0.
- R3: The status register sits at offset 0x04. Bits 0..3 are GPIO banks A..D, bits 4..6 are LEDs 0..2, bit 7 is SPI, bit 8 is SMBus, bit 9 is one-wire and bit 10 is the timer event. Each source bit reflects `src_req` sampled one clock earlier. Writes to this offset have no effect.
- R4: The mask bits map to groups as follows: bit 2 covers status bits 0..3, bit 3 covers bits 4..6, bit 4 covers SPI, bit 5 covers SMBus, bit 6 covers one-wire and bit 7 covers the timer event. Masking blocks the request from the output but leaves status unchanged.
- R5: In level style with the enable set, `irq_out` is high exactly when, one cycle earlier, some status bit was set and not blocked.
- R6: In edge style with the enable set, `irq_out` pulses for one cycle when the combined unmasked request rises. No further pulse occurs while the combined request stays high, even when more sources join.
- R7: With the global enable clear, `irq_out` stays 0 in both styles.
- R8: The prescale register sits at offset 0x08. Bits 3..0 hold the prescale value and bit 4 enables the time base. A written value above 14 is stored as 14.
- R9: With the time base enabled at prescale p, a tick occurs every 2^p cycles. With a nonzero count N at offset 0x0C, the timer event bit sets after N ticks. A count of 0 never sets it.
- R10: A write to offset 0x0C clears the timer event and restarts the tick count. A write to offset 0x08 restarts the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 10 | Peripheral request levels, ordered as the status bits |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for the previous cycle's address |
| irq_out | output | 1 | Host interrupt line |

## Verification
The hardest situations to reach from the ports are timer-driven. At the largest prescale the timer event only arrives after tens of thousands of cycles. The bench therefore programs prescale 14 with a count of 2 and probes the status bit just before and just after the 32768-cycle mark. Prescaler restart is only visible when the prescale register is rewritten faster than one tick period, so the bench repeats those writes in a loop and then confirms the event never set. Edge-style re-arming needs a second source to join while the first is still active, followed by a full drop and a new rise. A behavioural model compares the line and the read data on every clock.

// File: rtl/pia_pkg.sv
package pia_pkg;
  localparam int NUM_SRC   = 10;
  localparam int NUM_GRP   = 6;
  localparam int STAT_W    = NUM_SRC + 1;
  localparam int CTRL_W    = 2 + NUM_GRP;
  localparam int BIT_GEN   = 0;
  localparam int BIT_EDGE  = 1;
  localparam int BIT_MASK0 = 2;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_PRESC = 2'd2,
    SEL_TSET  = 2'd3
  } reg_sel_e;

  // status bit index -> mask group index
  function automatic int grp_of(input int idx);
    if (idx < 4)      return 0;
    else if (idx < 7) return 1;
    else              return idx - 5;
  endfunction
endpackage

// File: rtl/pia_regs.sv
module pia_regs
  import pia_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int PS_W   = 4,
  parameter int PS_MAX = 14,
  parameter int TSET_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [STAT_W-1:0] status_vec,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [PS_W-1:0]   ps_val_q,
  output logic              ps_en_q,
  output logic [TSET_W-1:0] tset_q,
  output logic              wr_presc,
  output logic              wr_tset,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [PS_W-1:0] PS_CAP = PS_W'(PS_MAX);

  reg_sel_e          sel;
  logic              wr_ctrl;
  logic [PS_W-1:0]   ps_req;
  logic [DATA_W-1:0] rd_mux;

  assign sel      = reg_sel_e'(bus_addr[3:2]);
  assign wr_ctrl  = bus_wr && (sel == SEL_CTRL);
  assign wr_presc = bus_wr && (sel == SEL_PRESC);
  assign wr_tset  = bus_wr && (sel == SEL_TSET);
  assign ps_req   = bus_wdata[PS_W-1:0];

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CTRL:  rd_mux[CTRL_W-1:0] = ctrl_q;
      SEL_STAT:  rd_mux[STAT_W-1:0] = status_vec;
      SEL_PRESC: begin
        rd_mux[PS_W-1:0] = ps_val_q;
        rd_mux[PS_W]     = ps_en_q;
      end
      SEL_TSET:  rd_mux[TSET_W-1:0] = tset_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      ps_val_q  <= '0;
      ps_en_q   <= 1'b0;
      tset_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (wr_presc) begin
        ps_val_q <= (ps_req > PS_CAP) ? PS_CAP : ps_req;
        ps_en_q  <= bus_wdata[PS_W];
      end
      if (wr_tset) tset_q <= bus_wdata[TSET_W-1:0];
      bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/pia_timebase.sv
module pia_timebase #(
  parameter int PS_W   = 4,
  parameter int PS_MAX = 14,
  parameter int TSET_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ps_en,
  input  logic [PS_W-1:0]   ps_val,
  input  logic [TSET_W-1:0] tset,
  input  logic              wr_presc,
  input  logic              wr_tset,
  output logic              timer_flag
);
  localparam int CNT_W = PS_MAX + 1;
  localparam logic [CNT_W-1:0]  ONE_C = CNT_W'(1);
  localparam logic [TSET_W-1:0] ONE_T = TSET_W'(1);

  logic [CNT_W-1:0]  presc_cnt;
  logic [CNT_W-1:0]  lim;
  logic [TSET_W-1:0] tick_cnt;
  logic [TSET_W-1:0] tick_nxt;
  logic              tick;
  logic              hit;

  assign lim      = (ONE_C << ps_val) - ONE_C;
  assign tick     = ps_en && !wr_presc && (presc_cnt == lim);
  assign tick_nxt = tick_cnt + ONE_T;
  assign hit      = tick && (tset != '0) && (tick_nxt == tset);

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_cnt  <= '0;
      tick_cnt   <= '0;
      timer_flag <= 1'b0;
    end else begin
      if (wr_presc || !ps_en || tick) presc_cnt <= '0;
      else                            presc_cnt <= presc_cnt + ONE_C;

      if (wr_tset) begin
        tick_cnt   <= '0;
        timer_flag <= 1'b0;
      end else if (tick) begin
        tick_cnt <= hit ? '0 : tick_nxt;
        if (hit) timer_flag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pia_combine.sv
module pia_combine
  import pia_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] status_vec,
  input  logic [CTRL_W-1:0] ctrl_q,
  output logic              pend,
  output logic              irq_q
);
  logic [STAT_W-1:0] blocked;
  logic              pend_prev_q;

  generate
    for (genvar i = 0; i < STAT_W; i++) begin : g_blk
      assign blocked[i] = ctrl_q[BIT_MASK0 + grp_of(i)];
    end
  endgenerate

  assign pend = |(status_vec & ~blocked);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_prev_q <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      pend_prev_q <= pend;
      irq_q       <= ctrl_q[BIT_GEN] &
                     (ctrl_q[BIT_EDGE] ? (pend & ~pend_prev_q) : pend);
    end
  end
endmodule

// File: rtl/periph_irq_agg.sv
module periph_irq_agg
  import pia_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int PS_W   = 4,
  parameter int PS_MAX = 14,
  parameter int TSET_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_out
);
  logic [NUM_SRC-1:0] src_q;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [PS_W-1:0]    ps_val_q;
  logic               ps_en_q;
  logic [TSET_W-1:0]  tset_q;
  logic               wr_presc;
  logic               wr_tset;
  logic               timer_flag;
  logic [STAT_W-1:0]  status_vec;
  logic               pend;

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src_req;
  end

  assign status_vec = {timer_flag, src_q};

  pia_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PS_W(PS_W),
    .PS_MAX(PS_MAX), .TSET_W(TSET_W)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .status_vec(status_vec), .ctrl_q(ctrl_q),
    .ps_val_q(ps_val_q), .ps_en_q(ps_en_q), .tset_q(tset_q),
    .wr_presc(wr_presc), .wr_tset(wr_tset), .bus_rdata(bus_rdata)
  );

  pia_timebase #(
    .PS_W(PS_W), .PS_MAX(PS_MAX), .TSET_W(TSET_W)
  ) u_tb (
    .clk(clk), .rst(rst), .ps_en(ps_en_q), .ps_val(ps_val_q),
    .tset(tset_q), .wr_presc(wr_presc), .wr_tset(wr_tset),
    .timer_flag(timer_flag)
  );

  pia_combine u_comb (
    .clk(clk), .rst(rst), .status_vec(status_vec), .ctrl_q(ctrl_q),
    .pend(pend), .irq_q(irq_out)
  );
endmodule

// File: rtl/periph_irq_agg_chk.sv
module periph_irq_agg_chk #(
  parameter int PS_W   = 4,
  parameter int PS_MAX = 14
) (
  input logic            clk,
  input logic            rst,
  input logic [9:0]      src_req,
  input logic [9:0]      src_q,
  input logic            irq_out,
  input logic            gen,
  input logic            edge_mode,
  input logic [PS_W-1:0] ps_val,
  input logic            pend,
  input logic            wr_tset,
  input logic            timer_flag
);
  // R1: first cycle out of reset is quiet
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !irq_out);

  // R3: source status follows the inputs one cycle later
  assert_status_track_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (src_q == $past(src_req)));

  // R5: level style follows the unmasked request
  assert_level_follow_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(gen) && !$past(edge_mode)) |-> (irq_out == $past(pend)));

  // R6: edge style never gives two consecutive high cycles
  assert_edge_single_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(edge_mode) && irq_out) |-> !$past(irq_out));

  // R7: disabled means quiet
  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(gen) |-> !irq_out);

  // R8: stored prescale never exceeds the cap
  assert_prescale_cap_R8: assert property (@(posedge clk) disable iff (rst)
    ps_val <= PS_W'(PS_MAX));

  // R10: count rewrite clears the event
  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $past(wr_tset) |-> !timer_flag);
endmodule

bind periph_irq_agg periph_irq_agg_chk #(.PS_W(PS_W), .PS_MAX(PS_MAX)) u_chk (
  .clk(clk), .rst(rst), .src_req(src_req), .src_q(src_q), .irq_out(irq_out),
  .gen(ctrl_q[0]), .edge_mode(ctrl_q[1]), .ps_val(ps_val_q), .pend(pend),
  .wr_tset(wr_tset), .timer_flag(timer_flag)
);

// File: tb/tb_periph_irq_agg.sv
`timescale 1ns/1ps
module tb_periph_irq_agg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  src_req = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  periph_irq_agg dut (
    .clk(clk), .rst(rst), .src_req(src_req), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  // ---------------- behavioural reference model ----------------
  int m_ctrl, m_psval, m_psen, m_tset, m_src, m_flag;
  int m_pcnt, m_tcnt, m_pprev, m_irq, m_rdata;

  function automatic int grp(input int i);
    if (i < 4) return 0;
    if (i < 7) return 1;
    return i - 5;
  endfunction

  always @(posedge clk) begin
    int stat, pend_o, sel, tick, n_irq, n_rd, n_pcnt, n_tcnt, n_flag, wv;
    if (rst) begin
      m_ctrl = 0; m_psval = 0; m_psen = 0; m_tset = 0; m_src = 0; m_flag = 0;
      m_pcnt = 0; m_tcnt = 0; m_pprev = 0; m_irq = 0; m_rdata = 0;
    end else begin
      stat = (m_flag << 10) | m_src;
      pend_o = 0;
      for (int i = 0; i < 11; i++)
        if (((stat >> i) & 1) && !((m_ctrl >> (2 + grp(i))) & 1)) pend_o = 1;
      if (m_ctrl & 1) n_irq = (m_ctrl & 2) ? (pend_o && !m_pprev) : pend_o;
      else            n_irq = 0;
      sel = int'(bus_addr) >> 2;
      case (sel)
        0: n_rd = m_ctrl;
        1: n_rd = stat;
        2: n_rd = (m_psen << 4) | m_psval;
        default: n_rd = m_tset;
      endcase
      tick = (m_psen && !(bus_wr && sel == 2) && m_pcnt == (1 << m_psval) - 1);
      n_pcnt = ((bus_wr && sel == 2) || !m_psen || tick) ? 0 : m_pcnt + 1;
      n_tcnt = m_tcnt; n_flag = m_flag;
      if (bus_wr && sel == 3) begin
        n_tcnt = 0; n_flag = 0;
      end else if (tick) begin
        if (m_tset != 0 && m_tcnt + 1 == m_tset) begin
          n_tcnt = 0; n_flag = 1;
        end else n_tcnt = (m_tcnt + 1) & 16'hFFFF;
      end
      if (bus_wr) begin
        wv = int'(bus_wdata);
        if (sel == 0) m_ctrl = wv & 8'hFF;
        if (sel == 2) begin
          m_psval = ((wv & 15) > 14) ? 14 : (wv & 15);
          m_psen  = (wv >> 4) & 1;
        end
        if (sel == 3) m_tset = wv;
      end
      m_pprev = pend_o; m_irq = n_irq; m_rdata = n_rd;
      m_pcnt = n_pcnt; m_tcnt = n_tcnt; m_flag = n_flag;
      m_src = int'(src_req);
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      checks++;
      if (int'(irq_out) != m_irq) begin
        errors++;
        $display("FAIL R5 model irq_out act=%0d exp=%0d t=%0t", irq_out, m_irq, $time);
      end
      checks++;
      if (int'(bus_rdata) != m_rdata) begin
        errors++;
        $display("FAIL R2 model rdata act=%0h exp=%0h t=%0t", bus_rdata, m_rdata, $time);
      end
    end
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- tasks ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = 4'(a); bus_wdata = 16'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    bus_addr = 4'(a); bus_wr = 1'b0;
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic pulses(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (irq_out) c++;
    end
  endtask

  initial begin
    int v, c;
    idle(3);
    rst = 1'b0;
    idle(1);
    chk(irq_out == 1'b0, "R1 irq after reset", int'(irq_out), 0);
    for (int a = 0; a < 16; a += 4) begin
      rd(a, v);
      chk(v == 0, "R1 register reset value", v, 0);
    end

    wr(0, 16'h00A4); rd(0, v); chk(v == 16'hA4, "R2 ctrl readback", v, 16'hA4);
    wr(0, 16'hFFFC); rd(0, v); chk(v == 16'hFC, "R2 upper bits zero", v, 16'hFC);
    wr(0, 0);

    src_req = 10'h2A5; idle(2);
    rd(4, v); chk(v == 16'h2A5, "R3 status mapping", v, 16'h2A5);
    wr(4, 16'hFFFF); rd(4, v); chk(v == 16'h2A5, "R3 status write ignored", v, 16'h2A5);
    src_req = '0; idle(2);

    wr(0, 16'h01); src_req = 10'h100; idle(4);
    chk(irq_out == 1'b1, "R5 level request SMBus", int'(irq_out), 1);
    wr(0, 16'h21); idle(3);
    chk(irq_out == 1'b0, "R4 SMBus masked", int'(irq_out), 0);
    rd(4, v); chk(v == 16'h100, "R4 status unaffected by mask", v, 16'h100);
    wr(0, 16'h09); src_req = 10'h020; idle(4);
    chk(irq_out == 1'b0, "R4 LED group masked", int'(irq_out), 0);
    src_req = 10'h021; idle(4);
    chk(irq_out == 1'b1, "R4 GPIO group passes", int'(irq_out), 1);
    src_req = '0; idle(4);
    chk(irq_out == 1'b0, "R5 level drops with request", int'(irq_out), 0);

    wr(0, 16'h00); src_req = 10'h3FF; idle(4);
    chk(irq_out == 1'b0, "R7 disabled level", int'(irq_out), 0);
    wr(0, 16'h02); src_req = '0; idle(3); src_req = 10'h080;
    pulses(8, c); chk(c == 0, "R7 disabled edge", c, 0);
    src_req = '0; idle(3);

    wr(0, 16'h03); idle(3);
    src_req = 10'h200; pulses(8, c);
    chk(c == 1, "R6 single pulse on rise", c, 1);
    src_req = 10'h204; pulses(8, c);
    chk(c == 0, "R6 no pulse while high", c, 0);
    src_req = '0; idle(4);
    src_req = 10'h010; pulses(8, c);
    chk(c == 1, "R6 re-arm after drop", c, 1);
    src_req = '0; idle(3);

    wr(8, 16'h1F); rd(8, v); chk(v == 16'h1E, "R8 clamp 15", v, 16'h1E);
    wr(8, 16'h0D); rd(8, v); chk(v == 16'h0D, "R8 value 13 kept", v, 16'h0D);
    wr(8, 16'h0E); rd(8, v); chk(v == 16'h0E, "R8 value 14 kept", v, 16'h0E);

    wr(0, 16'h01);
    wr(8, 16'h12); wr(12, 3);
    idle(2); rd(4, v); chk(((v >> 10) & 1) == 0, "R9 early timer", v, 0);
    idle(20); rd(4, v); chk(((v >> 10) & 1) == 1, "R9 timer event", v, 16'h400);
    chk(irq_out == 1'b1, "R4 timer unmasked irq", int'(irq_out), 1);
    wr(0, 16'h81); idle(3);
    chk(irq_out == 1'b0, "R4 timer masked", int'(irq_out), 0);
    wr(12, 3); rd(4, v); chk(((v >> 10) & 1) == 0, "R10 rewrite clears", v, 0);
    wr(12, 0); idle(100); rd(4, v);
    chk(((v >> 10) & 1) == 0, "R9 zero count never", v, 0);

    wr(8, 16'h13); wr(12, 1);
    for (int k = 0; k < 8; k++) begin
      idle(3); wr(8, 16'h13);
    end
    rd(4, v); chk(((v >> 10) & 1) == 0, "R10 prescaler restart", v, 0);

    wr(8, 16'h1E); wr(12, 2);
    idle(30000); rd(4, v);
    chk(((v >> 10) & 1) == 0, "R9 max prescale before", v, 0);
    idle(3500); rd(4, v);
    chk(((v >> 10) & 1) == 1, "R9 max prescale after", v, 16'h400);

    idle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule